// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block moves a processor into a low-power clock state and brings it back out again. Software starts a sequence by reading one of two level registers: level 2 or level 3. The read reaches this block as a one-cycle strobe. Configuration bits pick one of four states: stop-grant, sleep, stop-clock or deep-sleep. Each state has its own ordering of the outputs on the way in and on the way out. Those outputs are:

- a halt request to the processor,
- a sleep line,
- a stop request to the clock synthesizer,
- a refresh-hold status to the memory bridge,
- an optional low-power line to the cache SRAM.

Every state first raises the halt request and waits for the processor's acknowledge. After that, the state's own entry ordering runs. A wake request starts the exit ordering. The exits include two fixed delays: a settle delay in the sleep state and a two-clock gap. The clock-stopping states also run a countdown, loaded from a lock-time input, so the processor PLL can relock before the halt request is released. All timing is counted in PCI clocks. All outputs are active-high and registered.

Top module: `lps_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, all five outputs are 0 until a sequence starts.
- R2: With `cfg_enable` = 0, strobes on `rd_level2` and `rd_level3` start nothing and every output stays 0.
- R3: A `rd_level2` strobe with `cfg_enable` = 1 selects stop-grant, whatever the clock-stop and sleep enables are.
  - Entry: `halt_req` rises the edge after the strobe. On the edge that samples `halt_ack`, `cache_lp` rises if enabled.
  - `synth_stop` never rises in this state.
  - Exit: on the edge that samples the wake, `cache_lp` falls. `halt_req` falls one edge later.
- R4: A `rd_level3` strobe with `cfg_clkstop_en` = 0 and `cfg_sleep_en` = 0 starts nothing.
- R5: Sleep state is `rd_level3` with `cfg_sleep_en` = 1 and `cfg_clkstop_en` = 0. `core_sleep` rises exactly SLEEP_DLY edges after the edge that samples `halt_ack`.
- R6: Sleep exit:
  - `core_sleep` falls on the wake edge,
  - `cache_lp` falls RESUME_DLY edges later,
  - `halt_req` falls GAP_DLY edges after that.
- R7: Stop-clock state is `rd_level3` with `cfg_clkstop_en` = 1 and `cfg_sleep_en` = 0. On the acknowledge edge `cache_lp` rises if enabled. `refresh_hold` rises one edge later and `synth_stop` one edge after that.
- R8: Stop-clock exit, with L the value of `pll_lock_cnt` sampled at the wake edge:
  - `synth_stop` falls on the wake edge,
  - `refresh_hold` falls L+1 edges later,
  - `cache_lp` falls one edge after that,
  - `halt_req` falls one further edge later.
- R9: Deep-sleep state is `rd_level3` with both enables 1. From the acknowledge edge, one per edge in this order: `cache_lp` (if enabled), `core_sleep`, `refresh_hold`, `synth_stop`.
- R10: Deep-sleep exit:
  - `synth_stop` falls on the wake edge,
  - `core_sleep` falls L+1 edges later,
  - then `refresh_hold`, `cache_lp` and `halt_req` fall on successive edges.
- R11: With `cfg_cache_lp_en` = 0, `cache_lp` stays 0 through every state.
- R12: A `wake_req` that arrives while the entry is still in progress is held. The exit then starts on the edge after the entry completes. A `wake_req` while idle has no effect.
- R13: Level-register strobes while a sequence is active are ignored. When both strobes arrive together from idle, level 2 takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Clock-control enable |
| cfg_clkstop_en | input | 1 | Clock-stop enable for level-3 selection |
| cfg_sleep_en | input | 1 | Sleep enable for level-3 selection |
| cfg_cache_lp_en | input | 1 | Allows the cache SRAM low-power line |
| rd_level2 | input | 1 | One-cycle strobe: level-2 register read |
| rd_level3 | input | 1 | One-cycle strobe: level-3 register read |
| halt_ack | input | 1 | Stop-grant acknowledge from the processor |
| wake_req | input | 1 | Exit request |
| pll_lock_cnt | input | LOCK_W | Lock countdown value loaded on exit |
| halt_req | output | 1 | Stop-clock request to the processor |
| core_sleep | output | 1 | Sleep line to the processor |
| synth_stop | output | 1 | Clock-stop request to the clock synthesizer |
| refresh_hold | output | 1 | Suspend-status to the memory bridge |
| cache_lp | output | 1 | Low-power line to the cache SRAM |

## Verification
Some relations hold on every cycle, and the assertions check those:
- `synth_stop` is only high while both `refresh_hold` and `halt_req` are high.
- `core_sleep` and `cache_lp` stay under the halt request.
- `halt_req` falls only after every other output is already low.
- A stop-grant sequence never raises `synth_stop`.
- The idle block does not leave idle while clock control is disabled.

The exact edge counts, the per-state orderings, the lock countdown length and the handling of held wakes and ignored strobes are checked only by the bench's scenarios. The scoreboard in the bench compares every output change against the predicted vector and edge number.

// File: rtl/lps_pkg.sv
package lps_pkg;

   typedef enum logic [1:0] {
      MD_GRANT   = 2'd0,
      MD_SLEEP   = 2'd1,
      MD_STOPCLK = 2'd2,
      MD_DEEP    = 2'd3
   } lps_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_WAIT_ACK = 4'd1,
      ST_ENT_DLY  = 4'd2,
      ST_ENT_SLP  = 4'd3,
      ST_ENT_SUS  = 4'd4,
      ST_ENT_CLK  = 4'd5,
      ST_RESIDE   = 4'd6,
      ST_EX_LOCK  = 4'd7,
      ST_EX_SUS   = 4'd8,
      ST_EX_LP    = 4'd9,
      ST_EX_HALT  = 4'd10,
      ST_EX_RES   = 4'd11,
      ST_EX_GAP   = 4'd12
   } lps_state_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lps_mode_dec.sv
module lps_mode_dec
   import lps_pkg::*;
(
   input  logic      cfg_enable,
   input  logic      cfg_clkstop_en,
   input  logic      cfg_sleep_en,
   input  logic      rd_level2,
   input  logic      rd_level3,
   output logic      start,
   output lps_mode_e start_mode
);

   logic l3_valid;

   always_comb begin
      l3_valid = rd_level3 & (cfg_clkstop_en | cfg_sleep_en);
      start    = cfg_enable & (rd_level2 | l3_valid);
      if (rd_level2) begin
         start_mode = MD_GRANT;
      end else begin
         unique case ({cfg_clkstop_en, cfg_sleep_en})
            2'b01:   start_mode = MD_SLEEP;
            2'b10:   start_mode = MD_STOPCLK;
            2'b11:   start_mode = MD_DEEP;
            default: start_mode = MD_GRANT;
         endcase
      end
   end

endmodule

// File: rtl/lps_timer.sv
module lps_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

   p_timer_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero)
      else $error("timer left zero without a load");

endmodule

// File: rtl/lps_seq_fsm.sv
module lps_seq_fsm
   import lps_pkg::*;
#(
   parameter int SLEEP_DLY    = 50,
   parameter int RESUME_DLY   = 1056,
   parameter int GAP_DLY      = 2,
   parameter int LOCK_W       = 8,
   parameter int CNT_W        = 11,
   parameter bit HAS_CACHE_LP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_cache_lp_en,
   input  logic              start,
   input  lps_mode_e         start_mode,
   input  logic              halt_ack,
   input  logic              wake_req,
   input  logic [LOCK_W-1:0] pll_lock_cnt,
   input  logic              tmr_zero,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              halt_req,
   output logic              core_sleep,
   output logic              synth_stop,
   output logic              refresh_hold,
   output logic              cache_lp
);

   localparam logic [CNT_W-1:0] SLP_LD = CNT_W'(SLEEP_DLY - 1);
   localparam logic [CNT_W-1:0] RES_LD = CNT_W'(RESUME_DLY - 1);
   localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_DLY - 1);

   lps_state_e st_q, st_d;
   lps_mode_e  mode_q, mode_d;
   logic halt_q, halt_d, slp_q, slp_d, stop_q, stop_d;
   logic sus_q, sus_d, lp_q, lp_d;
   logic pend_q, in_entry, leaving, zz_allow;

   generate
      if (HAS_CACHE_LP) begin : g_lp_on
         assign zz_allow = cfg_cache_lp_en;
      end else begin : g_lp_off
         assign zz_allow = cfg_cache_lp_en & 1'b0;
      end
   endgenerate

   always_comb begin
      in_entry = (st_q == ST_WAIT_ACK) || (st_q == ST_ENT_DLY) ||
                 (st_q == ST_ENT_SLP)  || (st_q == ST_ENT_SUS) ||
                 (st_q == ST_ENT_CLK);
   end

   always_comb begin
      st_d     = st_q;
      mode_d   = mode_q;
      halt_d   = halt_q;
      slp_d    = slp_q;
      stop_d   = stop_q;
      sus_d    = sus_q;
      lp_d     = lp_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      leaving  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (start) begin
               mode_d = start_mode;
               halt_d = 1'b1;
               st_d   = ST_WAIT_ACK;
            end
         end
         ST_WAIT_ACK: begin
            if (halt_ack) begin
               lp_d = zz_allow;
               case (mode_q)
                  MD_GRANT:   st_d = ST_RESIDE;
                  MD_SLEEP: begin
                     tmr_load = 1'b1;
                     tmr_val  = SLP_LD;
                     st_d     = ST_ENT_DLY;
                  end
                  MD_STOPCLK: st_d = ST_ENT_SUS;
                  default:    st_d = ST_ENT_SLP;
               endcase
            end
         end
         ST_ENT_DLY: begin
            if (tmr_zero) begin
               slp_d = 1'b1;
               st_d  = ST_RESIDE;
            end
         end
         ST_ENT_SLP: begin
            slp_d = 1'b1;
            st_d  = ST_ENT_SUS;
         end
         ST_ENT_SUS: begin
            sus_d = 1'b1;
            st_d  = ST_ENT_CLK;
         end
         ST_ENT_CLK: begin
            stop_d = 1'b1;
            st_d   = ST_RESIDE;
         end
         ST_RESIDE: begin
            if (wake_req || pend_q) begin
               leaving = 1'b1;
               case (mode_q)
                  MD_GRANT: begin
                     lp_d = 1'b0;
                     st_d = ST_EX_HALT;
                  end
                  MD_SLEEP: begin
                     slp_d    = 1'b0;
                     tmr_load = 1'b1;
                     tmr_val  = RES_LD;
                     st_d     = ST_EX_RES;
                  end
                  default: begin
                     stop_d   = 1'b0;
                     tmr_load = 1'b1;
                     tmr_val  = CNT_W'(pll_lock_cnt);
                     st_d     = ST_EX_LOCK;
                  end
               endcase
            end
         end
         ST_EX_LOCK: begin
            if (tmr_zero) begin
               if (mode_q == MD_DEEP) begin
                  slp_d = 1'b0;
                  st_d  = ST_EX_SUS;
               end else begin
                  sus_d = 1'b0;
                  st_d  = ST_EX_LP;
               end
            end
         end
         ST_EX_SUS: begin
            sus_d = 1'b0;
            st_d  = ST_EX_LP;
         end
         ST_EX_LP: begin
            lp_d = 1'b0;
            st_d = ST_EX_HALT;
         end
         ST_EX_HALT: begin
            halt_d = 1'b0;
            st_d   = ST_IDLE;
         end
         ST_EX_RES: begin
            if (tmr_zero) begin
               lp_d     = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = GAP_LD;
               st_d     = ST_EX_GAP;
            end
         end
         ST_EX_GAP: begin
            if (tmr_zero) begin
               halt_d = 1'b0;
               st_d   = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= MD_GRANT;
         halt_q <= 1'b0;
         slp_q  <= 1'b0;
         stop_q <= 1'b0;
         sus_q  <= 1'b0;
         lp_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         mode_q <= mode_d;
         halt_q <= halt_d;
         slp_q  <= slp_d;
         stop_q <= stop_d;
         sus_q  <= sus_d;
         lp_q   <= lp_d;
         if (leaving) begin
            pend_q <= 1'b0;
         end else if (in_entry && wake_req) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign halt_req     = halt_q;
   assign core_sleep   = slp_q;
   assign synth_stop   = stop_q;
   assign refresh_hold = sus_q;
   assign cache_lp     = lp_q;

   p_grant_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_GRANT) |-> !stop_q)
      else $error("synthesizer stop raised in stop-grant state");

   p_disabled_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && !cfg_enable) |=> (st_q == ST_IDLE))
      else $error("sequence started while clock control disabled");

   p_sleep_under_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slp_q |-> (halt_q && (mode_q == MD_SLEEP || mode_q == MD_DEEP)))
      else $error("sleep line outside a sleep state");

   p_stop_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |-> (sus_q && halt_q))
      else $error("synthesizer stop without refresh hold");

   p_hold_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sus_q) |-> !stop_q)
      else $error("refresh hold released before synthesizer stop");

   p_lp_under_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lp_q |-> halt_q)
      else $error("cache low-power line outside a sequence");

   p_halt_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_q) |-> !(slp_q || stop_q || sus_q || lp_q))
      else $error("halt released before other outputs");

   p_busy_read_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && start) |=> $stable(mode_q))
      else $error("mode changed by a read during a sequence");

endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
   import lps_pkg::*;
#(
   parameter int SLEEP_DLY    = 50,
   parameter int RESUME_DLY   = 1056,
   parameter int GAP_DLY      = 2,
   parameter int LOCK_W       = 8,
   parameter bit HAS_CACHE_LP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_clkstop_en,
   input  logic              cfg_sleep_en,
   input  logic              cfg_cache_lp_en,
   input  logic              rd_level2,
   input  logic              rd_level3,
   input  logic              halt_ack,
   input  logic              wake_req,
   input  logic [LOCK_W-1:0] pll_lock_cnt,
   output logic              halt_req,
   output logic              core_sleep,
   output logic              synth_stop,
   output logic              refresh_hold,
   output logic              cache_lp
);

   localparam int DLY_W = max_i(max_i($clog2(SLEEP_DLY + 1), $clog2(RESUME_DLY + 1)),
                                $clog2(GAP_DLY + 1));
   localparam int CNT_W = max_i(DLY_W, LOCK_W);

   generate
      if (SLEEP_DLY < 1) begin : g_bad_sleep
         $error("SLEEP_DLY must be at least 1");
      end
      if (RESUME_DLY < 1) begin : g_bad_resume
         $error("RESUME_DLY must be at least 1");
      end
      if (GAP_DLY < 1) begin : g_bad_gap
         $error("GAP_DLY must be at least 1");
      end
      if (LOCK_W < 1) begin : g_bad_lock
         $error("LOCK_W must be at least 1");
      end
   endgenerate

   logic             start;
   lps_mode_e        start_mode;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_zero;

   lps_mode_dec u_dec (
      .cfg_enable     (cfg_enable),
      .cfg_clkstop_en (cfg_clkstop_en),
      .cfg_sleep_en   (cfg_sleep_en),
      .rd_level2      (rd_level2),
      .rd_level3      (rd_level3),
      .start          (start),
      .start_mode     (start_mode)
   );

   lps_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   lps_seq_fsm #(
      .SLEEP_DLY    (SLEEP_DLY),
      .RESUME_DLY   (RESUME_DLY),
      .GAP_DLY      (GAP_DLY),
      .LOCK_W       (LOCK_W),
      .CNT_W        (CNT_W),
      .HAS_CACHE_LP (HAS_CACHE_LP)
   ) u_fsm (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_enable      (cfg_enable),
      .cfg_cache_lp_en (cfg_cache_lp_en),
      .start           (start),
      .start_mode      (start_mode),
      .halt_ack        (halt_ack),
      .wake_req        (wake_req),
      .pll_lock_cnt    (pll_lock_cnt),
      .tmr_zero        (tmr_zero),
      .tmr_load        (tmr_load),
      .tmr_val         (tmr_val),
      .halt_req        (halt_req),
      .core_sleep      (core_sleep),
      .synth_stop      (synth_stop),
      .refresh_hold    (refresh_hold),
      .cache_lp        (cache_lp)
   );

endmodule

// File: tb/test_lps_sequencer.sv
`timescale 1ns/1ps
module test_lps_sequencer;

   localparam int SLP = 50;
   localparam int RES = 40;
   localparam int GAP = 2;
   localparam int LW  = 8;
   localparam int WD  = 100000;

   // output vector bit positions
   localparam int B_HALT = 0, B_SLP = 1, B_STOP = 2, B_SUS = 3, B_LP = 4;

   typedef struct {
      int         cyc;
      logic [4:0] vec;
      string      tag;
   } sb_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0, cfg_clkstop_en = 1'b0, cfg_sleep_en = 1'b0;
   logic cfg_cache_lp_en = 1'b0;
   logic rd_level2 = 1'b0, rd_level3 = 1'b0, halt_ack = 1'b0, wake_req = 1'b0;
   logic [LW-1:0] pll_lock_cnt = '0;
   logic halt_req, core_sleep, synth_stop, refresh_hold, cache_lp;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   sb_item_t sb_q[$];
   logic [4:0] exp_v = '0;
   logic [4:0] mon_prev = '0;
   logic [4:0] mon_cur;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   lps_sequencer #(
      .SLEEP_DLY (SLP), .RESUME_DLY (RES), .GAP_DLY (GAP), .LOCK_W (LW), .HAS_CACHE_LP (1'b1)
   ) i_lps_sequencer (
      .clk (clk), .rst_n (rst_n),
      .cfg_enable (cfg_enable), .cfg_clkstop_en (cfg_clkstop_en),
      .cfg_sleep_en (cfg_sleep_en), .cfg_cache_lp_en (cfg_cache_lp_en),
      .rd_level2 (rd_level2), .rd_level3 (rd_level3),
      .halt_ack (halt_ack), .wake_req (wake_req), .pll_lock_cnt (pll_lock_cnt),
      .halt_req (halt_req), .core_sleep (core_sleep), .synth_stop (synth_stop),
      .refresh_hold (refresh_hold), .cache_lp (cache_lp)
   );

   function automatic logic [4:0] outs();
      return {cache_lp, refresh_hold, synth_stop, core_sleep, halt_req};
   endfunction

   // driver side: predict an output change at edge 'at'
   function automatic void push(input int at, input int idx, input logic val, input string tag);
      if (exp_v[idx] !== val) begin
         exp_v[idx] = val;
         sb_q.push_back('{cyc: at, vec: exp_v, tag: tag});
      end
   endfunction

   // monitor: every output change must match the next predicted item
   always @(negedge clk) begin
      if (rst_n) begin
         mon_cur = outs();
         if (mon_cur !== mon_prev) begin
            n_chk++;
            if (sb_q.size() == 0) begin
               n_bad++;
               $display("FAIL unexpected change (R13/R12): actual=%b at edge %0d expected=no change",
                        mon_cur, cyc);
            end else begin
               sb_item_t it;
               it = sb_q.pop_front();
               if (it.vec !== mon_cur || it.cyc != cyc) begin
                  n_bad++;
                  $display("FAIL %s: actual=%b@%0d expected=%b@%0d",
                           it.tag, mon_cur, cyc, it.vec, it.cyc);
               end
            end
            mon_prev = mon_cur;
         end
      end
   end

   task automatic check_out(input logic [4:0] exp, input string tag);
      n_chk++;
      if (outs() !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b at edge %0d", tag, outs(), exp, cyc);
      end
   endtask

   task automatic check_drained(input string tag);
      n_chk++;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL %s: actual=%0d pending changes expected=0", tag, sb_q.size());
         sb_q.delete();
      end
   endtask

   // returns the edge that samples the strobe
   task automatic pulse(ref logic sig, output int edge_no);
      @(negedge clk);
      sig = 1'b1;
      edge_no = cyc + 1;
      @(negedge clk);
      sig = 1'b0;
   endtask

   // mode: 0 grant via level 2, 1 sleep, 2 stop-clock, 3 deep, 4 both strobes together
   task automatic run_seq(input int mode, input bit zz, input int lock, input bit early,
                          input bit busy_rd, input string t_in, input string t_out);
      int r, a, e, w, done, dummy;
      int m;
      m = (mode == 4) ? 0 : mode;
      cfg_enable      = 1'b1;
      cfg_cache_lp_en = zz;
      pll_lock_cnt    = LW'(lock);
      case (mode)
         1:       begin cfg_clkstop_en = 1'b0; cfg_sleep_en = 1'b1; end
         2:       begin cfg_clkstop_en = 1'b1; cfg_sleep_en = 1'b0; end
         default: begin cfg_clkstop_en = 1'b1; cfg_sleep_en = 1'b1; end
      endcase
      @(negedge clk);
      if (mode == 0) rd_level2 = 1'b1;
      else if (mode == 4) begin rd_level2 = 1'b1; rd_level3 = 1'b1; end
      else rd_level3 = 1'b1;
      r = cyc + 1;
      push(r, B_HALT, 1'b1, t_in);
      @(negedge clk);
      rd_level2 = 1'b0;
      rd_level3 = 1'b0;
      if (busy_rd) begin
         pulse(rd_level3, dummy);
         pulse(rd_level2, dummy);
         check_out(5'b00001, "R13");
      end
      repeat (2) @(negedge clk);
      if (early) pulse(wake_req, dummy);
      pulse(halt_ack, a);
      push(a, B_LP, zz, zz ? t_in : "R11");
      case (m)
         1: begin push(a + SLP, B_SLP, 1'b1, t_in); e = a + SLP; end
         2: begin
            push(a + 1, B_SUS, 1'b1, t_in);
            push(a + 2, B_STOP, 1'b1, t_in);
            e = a + 2;
         end
         3: begin
            push(a + 1, B_SLP, 1'b1, t_in);
            push(a + 2, B_SUS, 1'b1, t_in);
            push(a + 3, B_STOP, 1'b1, t_in);
            e = a + 3;
         end
         default: e = a;
      endcase
      if (early) begin
         w = e + 1;
      end else begin
         while (cyc < e + 3) @(negedge clk);
         check_out(exp_v, zz ? t_in : "R11");
         pulse(wake_req, w);
      end
      case (m)
         1: begin
            push(w, B_SLP, 1'b0, t_out);
            push(w + RES, B_LP, 1'b0, t_out);
            push(w + RES + GAP, B_HALT, 1'b0, t_out);
            done = w + RES + GAP;
         end
         2: begin
            push(w, B_STOP, 1'b0, t_out);
            push(w + lock + 1, B_SUS, 1'b0, t_out);
            push(w + lock + 2, B_LP, 1'b0, t_out);
            push(w + lock + 3, B_HALT, 1'b0, t_out);
            done = w + lock + 3;
         end
         3: begin
            push(w, B_STOP, 1'b0, t_out);
            push(w + lock + 1, B_SLP, 1'b0, t_out);
            push(w + lock + 2, B_SUS, 1'b0, t_out);
            push(w + lock + 3, B_LP, 1'b0, t_out);
            push(w + lock + 4, B_HALT, 1'b0, t_out);
            done = w + lock + 4;
         end
         default: begin
            push(w, B_LP, 1'b0, t_out);
            push(w + 1, B_HALT, 1'b0, t_out);
            done = w + 1;
         end
      endcase
      while (cyc < done + 3) @(negedge clk);
      check_out(5'b00000, t_out);
      check_drained(t_out);
   endtask

   initial begin : main
      int d;
      repeat (4) @(negedge clk);
      check_out(5'b00000, "R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_out(5'b00000, "R1 after reset");

      // R2: clock control disabled
      cfg_enable = 1'b0; cfg_clkstop_en = 1'b1; cfg_sleep_en = 1'b1;
      pulse(rd_level2, d);
      pulse(rd_level3, d);
      repeat (4) @(negedge clk);
      check_out(5'b00000, "R2");

      // R4: reserved level-3 selection
      cfg_enable = 1'b1; cfg_clkstop_en = 1'b0; cfg_sleep_en = 1'b0;
      pulse(rd_level3, d);
      repeat (4) @(negedge clk);
      check_out(5'b00000, "R4");

      // R12: wake while idle has no effect, later sequence must wait for a fresh wake
      pulse(wake_req, d);
      repeat (3) @(negedge clk);
      check_out(5'b00000, "R12 idle wake");

      run_seq(0, 1'b1, 0, 1'b0, 1'b0, "R3", "R3");
      run_seq(0, 1'b0, 0, 1'b0, 1'b1, "R3", "R13");
      run_seq(1, 1'b1, 0, 1'b0, 1'b0, "R5", "R6");
      run_seq(2, 1'b0, 5, 1'b0, 1'b0, "R7", "R8");
      run_seq(2, 1'b1, 0, 1'b0, 1'b0, "R7", "R8");
      run_seq(3, 1'b1, 0, 1'b0, 1'b0, "R9", "R10");
      run_seq(3, 1'b0, 7, 1'b0, 1'b0, "R9", "R10");
      run_seq(0, 1'b1, 0, 1'b1, 1'b0, "R12", "R12");
      run_seq(2, 1'b1, 3, 1'b1, 1'b0, "R12", "R12");
      run_seq(1, 1'b0, 0, 1'b1, 1'b0, "R12", "R12");
      run_seq(4, 1'b1, 0, 1'b0, 1'b0, "R13", "R13");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (WD) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule